// File: doc/BRIEF.md
# Hybrid Jump-Counter Sequencer

This block is a controller state machine built around a synchronous 4-bit binary counter instead of a next-state table. On each clock edge the counter does one of four things: it clears, loads a jump address, counts up by one, or holds. Which of these happens is chosen by a per-state multiplexer, indexed by the current state. A second small function produces the jump address. In this hybrid form the address depends on the current state and on the two opcode inputs.

The fixed program is a fetch/dispatch/execute controller. State 0 is the first fetch state and waits. State 1 counts. State 2 dispatches on the opcode. Each opcode then runs its own execute sequence, which ends with a clear back to state 0, or, for opcode 11, with a count that wraps from 15 to 0. Some states are waiting states: while the wait input is high in one of them, the machine holds. The current state is output both as a binary number and as a one-hot bus. The one-hot bus serves as the control outputs of the datapath.

Top module: `jcseq_top`

## Requirements
- R1: A high `rst` at a rising edge sets the state to 0 on that edge, in any state. This includes the dispatch state, so clear wins over load.
- R2: The plain counting states are 1, 3, 7, 10, 13 and 14. In each of them the state advances by exactly one per clock.
- R3: The waiting states are 0, 4, 6, 9 and 12. In any of them, a high `wait_i` keeps the state unchanged at the edge.
- R4: In a waiting state with `wait_i` low, the state advances by one.
- R5: The dispatch state is 2. From it, the state loads a target chosen by `op_i`: 00 gives 4, 01 gives 6, 10 gives 9 and 11 gives 12. Count is also requested in state 2, but load wins over it.
- R6: The clearing states are 5, 8 and 11. Each of them returns the state to 0 on the next edge.
- R7: State 15 counts, and the counter wraps to state 0.
- R8: `state_hot_o` has exactly one bit set, and that bit is bit `state_o`.
- R9: `wait_i` has no effect outside the waiting states. With it high, state 2 still loads and states 1 and 13 still count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, ORed into the clear control |
| op_i | input | 2 | Opcode bits used by the dispatch jump |
| wait_i | input | 1 | Stall request, honoured only in waiting states |
| state_o | output | 4 | Current state number |
| state_hot_o | output | 16 | One-hot decode of the current state |

## Verification
The bench aims at the places where the three controls overlap:
- **Reset during dispatch.** A design that ranked load above clear would jump to the opcode target instead of going to 0.
- **Dispatch with each of the four opcodes.** A design that ranked count above load would land in state 3. A wrong target table would land in the wrong sequence.
- **Stall behaviour.** `wait_i` is held high in each waiting state, and also in non-waiting states. A gating error shows either as a state that moves during a stall, or as a dispatch or count that freezes when it should not.
- **Longest sequence and the decode.** The longest sequence runs through state 15, so a wrap fault shows. The decoded bus is compared on every cycle.

// File: rtl/jcseq_pkg.sv
package jcseq_pkg;
    localparam int ST_W = 4;
    localparam int N_ST = 1 << ST_W;
    localparam int OP_W = 2;
    localparam int N_OP = 1 << OP_W;

    typedef logic [ST_W-1:0] state_t;

    typedef struct packed {
        state_t state;
    } seq_regs_t;

    // One bit per state; bit i describes state i.
    localparam logic [N_ST-1:0] CNT_MAP  = 16'hF6DF;
    localparam logic [N_ST-1:0] WAIT_MAP = 16'h1251;
    localparam logic [N_ST-1:0] LOAD_MAP = 16'h0004;
    localparam logic [N_ST-1:0] CLR_MAP  = 16'h0920;

    localparam state_t DISPATCH_ST = 4'd2;
    // Jump targets packed by opcode: op 3 in the top slice, op 0 in the bottom.
    localparam logic [N_OP*ST_W-1:0] JUMP_TGTS = {4'd12, 4'd9, 4'd6, 4'd4};
endpackage

// File: rtl/jcseq_ctl.sv
module jcseq_ctl
    import jcseq_pkg::*;
#(
    parameter int              SW       = ST_W,
    parameter int              NS       = N_ST,
    parameter logic [NS-1:0]   CNT_M    = CNT_MAP,
    parameter logic [NS-1:0]   WAIT_M   = WAIT_MAP,
    parameter logic [NS-1:0]   LOAD_M   = LOAD_MAP,
    parameter logic [NS-1:0]   CLR_M    = CLR_MAP
) (
    input  logic [SW-1:0] state,
    input  logic          wait_i,
    input  logic          rst,
    output logic          cnt,
    output logic          ld_n,
    output logic          clr_n
);
    logic [NS-1:0] cnt_in;
    logic [NS-1:0] ld_n_in;
    logic [NS-1:0] clrm_in;

    // Inputs of the three state-indexed multiplexers.
    for (genvar i = 0; i < NS; i++) begin : g_mux_in
        logic stall;
        assign stall      = WAIT_M[i] & wait_i;
        assign cnt_in[i]  = CNT_M[i] & ~stall;
        assign ld_n_in[i] = ~(LOAD_M[i] & ~stall);
        assign clrm_in[i] = CLR_M[i];
    end

    always_comb begin
        cnt   = cnt_in[state];
        ld_n  = ld_n_in[state];
        clr_n = ~(clrm_in[state] | rst);
    end
endmodule

// File: rtl/jcseq_jump.sv
module jcseq_jump
    import jcseq_pkg::*;
#(
    parameter int                  SW    = ST_W,
    parameter int                  OW    = OP_W,
    parameter logic [SW-1:0]       DISP  = DISPATCH_ST,
    parameter logic [(1<<OW)*SW-1:0] TGTS = JUMP_TGTS
) (
    input  logic [SW-1:0] state,
    input  logic [OW-1:0] op_i,
    output logic [SW-1:0] target
);
    localparam int NO = 1 << OW;
    logic [SW-1:0] tgt_tab [NO];

    for (genvar k = 0; k < NO; k++) begin : g_tab
        assign tgt_tab[k] = TGTS[k*SW +: SW];
    end

    always_comb begin
        if (state == DISP) target = tgt_tab[op_i];
        else               target = state;
    end
endmodule

// File: rtl/jcseq_decode.sv
module jcseq_decode #(
    parameter int SW = 4,
    parameter int NS = 1 << SW
) (
    input  logic [SW-1:0] state,
    output logic [NS-1:0] hot
);
    for (genvar i = 0; i < NS; i++) begin : g_line
        assign hot[i] = (state == SW'(i));
    end
endmodule

// File: rtl/jcseq_top.sv
module jcseq_top
    import jcseq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_i,
    input  logic            wait_i,
    output logic [ST_W-1:0] state_o,
    output logic [N_ST-1:0] state_hot_o
);
    seq_regs_t cur_q, nxt_d;
    logic      cnt, ld_n, clr_n;
    state_t    jump_tgt;

    jcseq_ctl u_ctl (
        .state (cur_q.state),
        .wait_i(wait_i),
        .rst   (rst),
        .cnt   (cnt),
        .ld_n  (ld_n),
        .clr_n (clr_n)
    );

    jcseq_jump u_jump (
        .state (cur_q.state),
        .op_i  (op_i),
        .target(jump_tgt)
    );

    jcseq_decode #(.SW(ST_W), .NS(N_ST)) u_dec (
        .state(cur_q.state),
        .hot  (state_hot_o)
    );

    // Priority: clear, then load, then count, else hold.
    always_comb begin
        nxt_d = cur_q;
        if (!clr_n)     nxt_d.state = '0;
        else if (!ld_n) nxt_d.state = jump_tgt;
        else if (cnt)   nxt_d.state = cur_q.state + 1'b1;
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign state_o = cur_q.state;

    // R8: decode agrees with the binary state
    a_r8_onehot: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> ($onehot(state_hot_o) && state_hot_o[state_o]));

    // R3: stall in a waiting state holds
    a_r3_wait_hold: assert property (@(posedge clk) disable iff (rst)
        (WAIT_MAP[state_o] && wait_i) |=> $stable(state_o));

    // R6: clearing states return to 0
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        CLR_MAP[state_o] |=> (state_o == '0));

    // R5: dispatch takes the jump target
    a_r5_dispatch: assert property (@(posedge clk) disable iff (rst)
        (state_o == DISPATCH_ST) |=> (state_o == $past(jump_tgt)));

    // R7: last state wraps to 0
    a_r7_wrap: assert property (@(posedge clk) disable iff (rst)
        (&state_o) |=> (state_o == '0));
endmodule

// File: tb/jcseq_top_test.sv
module jcseq_top_test;
    import jcseq_pkg::*;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [OP_W-1:0] op_i = '0;
    logic            wait_i = 1'b0;
    logic [ST_W-1:0] state_o;
    logic [N_ST-1:0] state_hot_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [3:0] exp;
        string      req;
    } item_t;
    item_t sb [$];
    logic [3:0] mstate;

    always #2 clk = ~clk; // 250 MHz

    jcseq_top uut (
        .clk(clk), .rst(rst), .op_i(op_i), .wait_i(wait_i),
        .state_o(state_o), .state_hot_o(state_hot_o)
    );

    // Expected next state, written from the requirements.
    function automatic logic [3:0] model(logic [3:0] s, logic r, logic [1:0] op, logic w);
        if (r) return 4'd0;                                      // R1
        if (s == 4'd5 || s == 4'd8 || s == 4'd11) return 4'd0;  // R6
        if (s == 4'd2) begin                                     // R5
            case (op)
                2'b00: return 4'd4;
                2'b01: return 4'd6;
                2'b10: return 4'd9;
                default: return 4'd12;
            endcase
        end
        if ((s == 4'd0 || s == 4'd4 || s == 4'd6 || s == 4'd9 || s == 4'd12) && w)
            return s;                                            // R3
        return s + 4'd1;                                         // R2 R4 R7
    endfunction

    task automatic step(logic r, logic [1:0] op, logic w, string req);
        item_t it;
        @(negedge clk);
        rst = r; op_i = op; wait_i = w;
        it.exp = model(mstate, r, op, w);
        it.req = req;
        sb.push_back(it);
        mstate = it.exp;
    endtask

    // Monitor: compare one item per edge, 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            n_checks++;
            if (state_o !== it.exp) begin
                n_fail++;
                $display("FAIL %s state actual=%0d expected=%0d", it.req, state_o, it.exp);
            end
            n_checks++;
            if (state_hot_o !== (16'd1 << it.exp)) begin
                n_fail++;
                $display("FAIL R8 hot actual=%h expected=%h", state_hot_o, 16'd1 << it.exp);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        mstate = 4'd0;
        step(1, 2'b00, 0, "R1_reset");
        step(1, 2'b00, 1, "R1_reset");
        // R3 stall in fetch, then R4 release
        step(0, 2'b00, 1, "R3_hold_s0");
        step(0, 2'b00, 1, "R3_hold_s0");
        step(0, 2'b00, 0, "R4_s0_count");
        step(0, 2'b00, 1, "R9_s1_counts");      // wait ignored in state 1
        step(0, 2'b00, 1, "R9_R5_dispatch_op0");// wait ignored in dispatch
        step(0, 2'b00, 1, "R3_hold_s4");
        step(0, 2'b00, 0, "R4_s4_count");
        step(0, 2'b00, 0, "R6_clear_s5");
        // opcode 01
        step(0, 2'b01, 0, "R4_s0");
        step(0, 2'b01, 0, "R2_s1");
        step(0, 2'b01, 0, "R5_dispatch_op1");
        step(0, 2'b01, 1, "R3_hold_s6");
        step(0, 2'b01, 0, "R4_s6");
        step(0, 2'b01, 0, "R2_s7");
        step(0, 2'b01, 0, "R6_clear_s8");
        // opcode 10
        step(0, 2'b10, 0, "R4_s0");
        step(0, 2'b10, 0, "R2_s1");
        step(0, 2'b10, 0, "R5_dispatch_op2");
        step(0, 2'b10, 1, "R3_hold_s9");
        step(0, 2'b10, 0, "R4_s9");
        step(0, 2'b10, 0, "R2_s10");
        step(0, 2'b10, 0, "R6_clear_s11");
        // opcode 11 through the wrap
        step(0, 2'b11, 0, "R4_s0");
        step(0, 2'b11, 0, "R2_s1");
        step(0, 2'b11, 0, "R5_dispatch_op3");
        step(0, 2'b11, 1, "R3_hold_s12");
        step(0, 2'b11, 0, "R4_s12");
        step(0, 2'b11, 1, "R9_s13_counts");
        step(0, 2'b11, 0, "R2_s14");
        step(0, 2'b11, 0, "R7_wrap_s15");
        // R1 reset while in dispatch: clear beats load
        step(0, 2'b01, 0, "R4_s0");
        step(0, 2'b01, 0, "R2_s1");
        step(1, 2'b01, 0, "R1_clear_over_load");
        step(0, 2'b01, 0, "R4_s0");
        step(1, 2'b01, 1, "R1_reset_s1");
        step(0, 2'b00, 0, "R4_s0");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule